// File: doc/BRIEF.md
# Reset Source Capture Register

This block collects every source that can reset the system, decides which of them are allowed to do so under the current configuration, and records why the last reset happened. Detector outputs from the supply monitors, the synchronized external reset pin, the watchdog timeout, the CPU's illegal-opcode and illegal-address events, and a clock-loss event come in. Configuration bits enable or block some of them. Out go a registered system reset request, an exception request for address faults that are not allowed to reset, and a watchdog-clear strobe.

The cause is held in an 8-bit read-only status byte, one bit per source. The byte is loaded only on the cycle the reset request first rises, so software reads it after reset to find out what happened. Writing to the byte does not change it. Instead, each write sends a one-cycle clear pulse to the watchdog counter, which lives outside this block.

Top module: `rst_cause_capture`

## Requirements
- R1: Status bit positions are: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 clock loss, bit 1 low voltage. Bit 0 always reads 0. After `rst` the byte is 0x00 and all outputs are low.
- R2: A power-on detect loads the byte with 0x82 (power-on and low-voltage bits set), whatever other sources are active.
- R3: A low-voltage reset without power-on sets bit 1, keeps bit 7 at its previous value, and clears bits 6 to 2.
- R4: On any other reset, bits 6 to 2 take the qualified state of their sources at reset entry, and bits 7 and 1 are cleared. Qualifying sources in the same cycle all set their bits together.
- R5: A cycle with `reg_wr` high leaves the byte unchanged and drives `wdog_clr` high for exactly the next cycle.
- R6: A watchdog timeout causes a reset only while `cfg_wdog_en` is 1. Otherwise it has no effect.
- R7: With `cfg_addr_rst_dis` = 0, an illegal-address event causes a reset. With it set to 1, the event raises `addr_exc_req` one cycle later for one cycle, no reset occurs and the byte is unchanged.
- R8: A stop event counts as an illegal opcode only when `cfg_stop_en` and `cfg_wait_en` are both 0.
- R9: A halt event counts as an illegal opcode only when `cfg_dbg_en` is 0.
- R10: `rst_pin_n` passes through a 2-flop synchronizer. A low level first sampled on clock edge N raises the request after edge N+2.
- R11: `sys_rst_req` rises on the clock edge that samples a qualifying source. It stays high for exactly 16 cycles after the last qualifying source, and a new source during the request restarts the 16.
- R12: The byte is loaded only on reset entry, the cycle the request rises. Sources that qualify while the request is already high leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| por_det | input | 1 | Power-on detect |
| lvd_det | input | 1 | Low-voltage detect |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_timeout | input | 1 | Watchdog timeout event |
| illop_evt | input | 1 | Illegal or privileged opcode event |
| stop_evt | input | 1 | Stop instruction executed |
| halt_evt | input | 1 | Halt instruction executed |
| illad_evt | input | 1 | Illegal address or address fault event |
| clk_loss | input | 1 | Clock-loss event |
| cfg_wdog_en | input | 1 | Watchdog reset enable |
| cfg_addr_rst_dis | input | 1 | 1 turns address faults into exceptions |
| cfg_stop_en | input | 1 | Stop mode allowed |
| cfg_wait_en | input | 1 | Wait mode allowed |
| cfg_dbg_en | input | 1 | Debug interface enabled |
| reg_wr | input | 1 | Write strobe to the status byte |
| rd_data | output | 8 | Status byte |
| sys_rst_req | output | 1 | Registered system reset request |
| addr_exc_req | output | 1 | Address-fault exception request |
| wdog_clr | output | 1 | One-cycle watchdog clear |

## Verification
Every result except the pin path is due one cycle after the input is sampled. This covers the new status byte, the request rise, `addr_exc_req` and `wdog_clr`. The pin path is due three cycles after, because of the two synchronizer flops. The request falls 17 cycles after the last qualifying source was applied. The driver stamps each expected item with the cycle it is due in, computed from these latencies. The monitor compares items only in that cycle, half a clock away from the active edge, and any item left unchecked at the end counts as a failure.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int STAT_W = 8;
    localparam int B_POR  = 7;
    localparam int B_PIN  = 6;
    localparam int B_WDOG = 5;
    localparam int B_ILOP = 4;
    localparam int B_ILAD = 3;
    localparam int B_LOC  = 2;
    localparam int B_LVD  = 1;

    typedef struct packed {
        logic por;
        logic pin;
        logic wdog;
        logic ilop;
        logic ilad;
        logic loc;
        logic lvd;
    } src_t;

    function automatic logic src_any(src_t s);
        return |s;
    endfunction

    function automatic logic [STAT_W-1:0] next_status(src_t s, logic [STAT_W-1:0] cur);
        logic [STAT_W-1:0] v;
        v = '0;
        if (s.por) begin
            v[B_POR] = 1'b1;
            v[B_LVD] = 1'b1;
        end else if (s.lvd) begin
            v[B_POR] = cur[B_POR];
            v[B_LVD] = 1'b1;
        end else begin
            v[B_PIN]  = s.pin;
            v[B_WDOG] = s.wdog;
            v[B_ILOP] = s.ilop;
            v[B_ILAD] = s.ilad;
            v[B_LOC]  = s.loc;
        end
        return v;
    endfunction
endpackage

// File: rtl/rcc_pin_sync.sv
module rcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    output logic pin_act_o
);
    logic [STAGES-1:0] sync_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin_n_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[STAGES-2:0], pin_n_i};
            end
        end
    endgenerate

    assign pin_act_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/rcc_qualify.sv
module rcc_qualify
    import rcc_pkg::*;
(
    input  logic por_det,
    input  logic lvd_det,
    input  logic pin_act,
    input  logic wdog_timeout,
    input  logic illop_evt,
    input  logic stop_evt,
    input  logic halt_evt,
    input  logic illad_evt,
    input  logic clk_loss,
    input  logic cfg_wdog_en,
    input  logic cfg_addr_rst_dis,
    input  logic cfg_stop_en,
    input  logic cfg_wait_en,
    input  logic cfg_dbg_en,
    output src_t qual_o,
    output logic exc_o
);
    logic stop_bad, halt_bad;

    always_comb begin
        stop_bad     = stop_evt & ~cfg_stop_en & ~cfg_wait_en;
        halt_bad     = halt_evt & ~cfg_dbg_en;
        qual_o.por   = por_det;
        qual_o.lvd   = lvd_det;
        qual_o.pin   = pin_act;
        qual_o.wdog  = wdog_timeout & cfg_wdog_en;
        qual_o.ilop  = illop_evt | stop_bad | halt_bad;
        qual_o.ilad  = illad_evt & ~cfg_addr_rst_dis;
        qual_o.loc   = clk_loss;
        exc_o        = illad_evt & cfg_addr_rst_dis;
    end
endmodule

// File: rtl/rcc_req_timer.sv
module rcc_req_timer #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic req_o,
    output logic entry_o
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (trig_i)         cnt_q <= LOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign req_o   = (cnt_q != '0);
    assign entry_o = trig_i & ~req_o;
endmodule

// File: rtl/rst_cause_capture.sv
module rst_cause_capture
    import rcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_det,
    input  logic       lvd_det,
    input  logic       rst_pin_n,
    input  logic       wdog_timeout,
    input  logic       illop_evt,
    input  logic       stop_evt,
    input  logic       halt_evt,
    input  logic       illad_evt,
    input  logic       clk_loss,
    input  logic       cfg_wdog_en,
    input  logic       cfg_addr_rst_dis,
    input  logic       cfg_stop_en,
    input  logic       cfg_wait_en,
    input  logic       cfg_dbg_en,
    input  logic       reg_wr,
    output logic [7:0] rd_data,
    output logic       sys_rst_req,
    output logic       addr_exc_req,
    output logic       wdog_clr
);
    logic              pin_act;
    src_t              qual;
    logic              exc_next;
    logic              entry;
    logic [STAT_W-1:0] stat_q;
    logic              exc_q, clr_q;

    rcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_n_i(rst_pin_n), .pin_act_o(pin_act)
    );

    rcc_qualify u_qual (
        .por_det(por_det), .lvd_det(lvd_det), .pin_act(pin_act),
        .wdog_timeout(wdog_timeout), .illop_evt(illop_evt),
        .stop_evt(stop_evt), .halt_evt(halt_evt), .illad_evt(illad_evt),
        .clk_loss(clk_loss), .cfg_wdog_en(cfg_wdog_en),
        .cfg_addr_rst_dis(cfg_addr_rst_dis), .cfg_stop_en(cfg_stop_en),
        .cfg_wait_en(cfg_wait_en), .cfg_dbg_en(cfg_dbg_en),
        .qual_o(qual), .exc_o(exc_next)
    );

    rcc_req_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .trig_i(src_any(qual)),
        .req_o(sys_rst_req), .entry_o(entry)
    );

    // status loads only on reset entry; writes never touch it
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            exc_q  <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            if (entry) stat_q <= next_status(qual, stat_q);
            exc_q <= exc_next;
            clr_q <= reg_wr;
        end
    end

    assign rd_data      = stat_q;
    assign addr_exc_req = exc_q;
    assign wdog_clr     = clr_q;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
    input logic       clk,
    input logic       rst,
    input logic       por_det,
    input logic       illad_evt,
    input logic       cfg_addr_rst_dis,
    input logic       reg_wr,
    input logic [7:0] rd_data,
    input logic       sys_rst_req,
    input logic       addr_exc_req,
    input logic       wdog_clr
);
    a_r1_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[0] == 1'b0);

    a_r2_por_value: assert property (@(posedge clk) disable iff (rst)
        (por_det && !sys_rst_req) |=> (rd_data == 8'h82));

    a_r4_entry_nonzero: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_req) |-> (rd_data != 8'h00));

    a_r5_clr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> wdog_clr);

    a_r5_clr_quiet: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> !wdog_clr);

    a_r7_exc_raise: assert property (@(posedge clk) disable iff (rst)
        (illad_evt && cfg_addr_rst_dis) |=> addr_exc_req);

    a_r12_hold_between: assert property (@(posedge clk) disable iff (rst)
        !$rose(sys_rst_req) |-> $stable(rd_data));
endmodule

bind rst_cause_capture rcc_checker chk_i (
    .clk(clk), .rst(rst), .por_det(por_det), .illad_evt(illad_evt),
    .cfg_addr_rst_dis(cfg_addr_rst_dis), .reg_wr(reg_wr),
    .rd_data(rd_data), .sys_rst_req(sys_rst_req),
    .addr_exc_req(addr_exc_req), .wdog_clr(wdog_clr)
);

// File: tb/rst_cause_capture_tb_top.sv
module rst_cause_capture_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_det = 0, lvd_det = 0, rst_pin_n = 1, wdog_timeout = 0;
    logic illop_evt = 0, stop_evt = 0, halt_evt = 0, illad_evt = 0, clk_loss = 0;
    logic cfg_wdog_en = 1, cfg_addr_rst_dis = 0, cfg_stop_en = 1, cfg_wait_en = 1, cfg_dbg_en = 1;
    logic reg_wr = 0;
    logic [7:0] rd_data;
    logic sys_rst_req, addr_exc_req, wdog_clr;

    always #5 clk = ~clk;

    rst_cause_capture dut_i (.*);

    typedef struct {
        int         due;
        int         field; // 0 rd_data, 1 req, 2 exc, 3 clr
        logic [7:0] val;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int cyc = 0;
    int n_checks = 0;
    int n_errs = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int field, logic [7:0] val, int dly, string tag);
        item_t it;
        it.due = cyc + dly; it.field = field; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                logic [7:0] act;
                case (sb_q[i].field)
                    0:       act = rd_data;
                    1:       act = {7'd0, sys_rst_req};
                    2:       act = {7'd0, addr_exc_req};
                    default: act = {7'd0, wdog_clr};
                endcase
                n_checks++;
                if (act !== sb_q[i].val) begin
                    n_errs++;
                    $display("FAIL %s field=%0d cycle=%0d actual=0x%02h expected=0x%02h",
                             sb_q[i].tag, sb_q[i].field, cyc, act, sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    // driver
    initial begin
        idle(4);
        rst = 1'b0;
        expect_at(0, 8'h00, 1, "R1 reset byte");
        expect_at(1, 0, 1, "R1 reset req");
        expect_at(2, 0, 1, "R1 reset exc");
        expect_at(3, 0, 1, "R1 reset clr");
        idle(3);

        // R2 power-on, with watchdog also active
        por_det = 1; wdog_timeout = 1;
        expect_at(0, 8'h82, 1, "R2 por byte");
        expect_at(1, 1, 1, "R11 req rise");
        expect_at(1, 1, 16, "R11 req held 16");
        expect_at(1, 0, 17, "R11 req fall");
        idle(1); por_det = 0; wdog_timeout = 0; idle(20);

        // R5 write
        reg_wr = 1;
        expect_at(3, 1, 1, "R5 clr pulse");
        expect_at(3, 0, 2, "R5 clr one cycle");
        expect_at(0, 8'h82, 2, "R5 byte unchanged");
        idle(1); reg_wr = 0; idle(4);

        // R3 low voltage keeps power-on bit
        lvd_det = 1;
        expect_at(0, 8'h82, 1, "R3 lvd keeps bit7");
        idle(1); lvd_det = 0; idle(20);

        // R4 simultaneous sources
        wdog_timeout = 1; illop_evt = 1; clk_loss = 1;
        expect_at(0, 8'h34, 1, "R4 multi bits");
        idle(1); wdog_timeout = 0; illop_evt = 0; clk_loss = 0; idle(20);

        // R3 low voltage with bit7 clear
        lvd_det = 1; clk_loss = 1;
        expect_at(0, 8'h02, 1, "R3 lvd clears others");
        idle(1); lvd_det = 0; clk_loss = 0; idle(20);

        // R6 watchdog blocked
        cfg_wdog_en = 0; wdog_timeout = 1;
        expect_at(1, 0, 1, "R6 wdog blocked req");
        expect_at(0, 8'h02, 1, "R6 wdog blocked byte");
        idle(1); wdog_timeout = 0; cfg_wdog_en = 1; idle(3);

        // R7 address fault as exception, then as reset
        cfg_addr_rst_dis = 1; illad_evt = 1;
        expect_at(2, 1, 1, "R7 exc raised");
        expect_at(2, 0, 2, "R7 exc one cycle");
        expect_at(1, 0, 1, "R7 no reset");
        expect_at(0, 8'h02, 2, "R7 byte unchanged");
        idle(1); illad_evt = 0; cfg_addr_rst_dis = 0; idle(3);
        illad_evt = 1;
        expect_at(0, 8'h08, 1, "R7 ilad reset");
        expect_at(2, 0, 1, "R7 no exc when enabled");
        idle(1); illad_evt = 0; idle(20);

        // R8 stop qualification
        cfg_stop_en = 0; stop_evt = 1;
        expect_at(1, 0, 1, "R8 stop wait_en set");
        idle(1); stop_evt = 0; idle(2);
        cfg_stop_en = 1; cfg_wait_en = 0; stop_evt = 1;
        expect_at(1, 0, 1, "R8 stop stop_en set");
        expect_at(0, 8'h08, 1, "R8 byte kept");
        idle(1); stop_evt = 0; idle(2);
        cfg_stop_en = 0; stop_evt = 1;
        expect_at(0, 8'h10, 1, "R8 stop illegal");
        idle(1); stop_evt = 0; cfg_stop_en = 1; cfg_wait_en = 1; idle(20);

        // R10 pin via synchronizer
        rst_pin_n = 0;
        expect_at(1, 0, 2, "R10 pin not yet");
        expect_at(1, 1, 3, "R10 pin req");
        expect_at(0, 8'h40, 3, "R10 pin byte");
        idle(1); rst_pin_n = 1; idle(22);

        // R9 halt qualification
        halt_evt = 1;
        expect_at(1, 0, 1, "R9 halt dbg on");
        expect_at(0, 8'h40, 1, "R9 byte kept");
        idle(1); halt_evt = 0; idle(2);
        cfg_dbg_en = 0; halt_evt = 1;
        expect_at(0, 8'h10, 1, "R9 halt illegal");
        idle(1); halt_evt = 0; cfg_dbg_en = 1; idle(4);

        // R12 source during request: byte held, R11 retrigger
        clk_loss = 1;
        expect_at(0, 8'h10, 1, "R12 byte held");
        expect_at(1, 1, 16, "R11 retrigger held");
        expect_at(1, 0, 17, "R11 retrigger fall");
        idle(1); clk_loss = 0; idle(20);

        if (sb_q.size() != 0) begin
            n_errs += sb_q.size();
            $display("FAIL R1 unchecked items actual=%0d expected=0", sb_q.size());
        end
        done = 1;
    end

    initial begin
        int w;
        w = 0;
        while (!done && w < 200000) begin
            @(posedge clk);
            w++;
        end
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule